// File: doc/BRIEF.md
# External Status Change Interrupt Unit

This unit watches the modem and line-status sources of one serial channel and raises an external/status interrupt when an enabled source changes state, in either direction. The level sources are clear-to-send, data-carrier-detect, a combined sync/hunt source, a break/abort flag and a transmit underrun/end-of-message latch. A baud counter zero-count pulse is the one event source. The three modem pins are active low and pass through a synchronizer chain before they are compared.

An eight-bit enable register is loaded over a write strobe and can be read back. While no interrupt is pending, a status register follows the live source values. On the cycle an interrupt is raised it captures them and then stays frozen until the host pulses a clear command. The frozen value is the reference for change detection. Any source that moved while the register was frozen therefore raises a new interrupt as soon as the clear has taken effect. A mode input selects whether the sync/hunt slot reflects the sync pin (asynchronous mode) or the receiver hunt flag (synchronous mode).

Top module: `extstat_irq_unit`

## Requirements
- R1: After the hardware reset, `en_rd` reads 0xF8, `es_status` reads 0x00, and `es_pending`, `es_irq` and `fifo_en` are 0. The synchronizer flops reset to the inactive (high) pin level.
- R2: A write stores `en_wdata` with bit 2 forced to 0, so bit 2 always reads 0 and writing it has no effect.
- R3: The status bit layout is: bit 7 break/abort, bit 6 underrun/EOM, bit 5 CTS asserted, bit 4 sync/hunt, bit 3 DCD asserted, bit 2 zero, bit 1 zero-count event, bit 0 zero. When the matching enable bit (7..3) is 1 and a level source differs from the value held in `es_status`, `es_pending` rises on the next clock edge for a rising or a falling change. For the pins this is the third edge after the pin changes, because of the two-flop synchronizer.
- R4: A change on a source whose enable bit is 0 raises no interrupt. While nothing is pending, `es_status` still follows the live values one cycle later.
- R5: With `sync_mode` = 0, status bit 4 and its change detection use the synchronized sync pin (asserted = 1) and ignore `rx_hunt`. With `sync_mode` = 1 they use `rx_hunt` and ignore the pin.
- R6: A one-cycle `zero_cnt` pulse with enable bit 1 set raises `es_pending` on the next edge, and status bit 1 reads 1 while frozen.
- R7: While `es_pending` is 1, `es_status` does not change.
- R8: An `es_clr` pulse clears `es_pending` on the next edge and takes priority over a new change in that cycle. If a source then differs from the frozen status and is enabled, `es_pending` rises again one edge later.
- R9: `es_irq` is `es_pending` gated by `mie`, with no added delay.
- R10: Writing the enable register, including writing 0, never clears a pending interrupt.
- R11: A `chan_rst` pulse sets enable bits 7..3, clears bits 2..0, and clears `es_pending` on the next edge. It takes priority over a write in the same cycle.
- R12: `fifo_en` follows enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| chan_rst | input | 1 | Channel reset pulse, synchronous |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| mie | input | 1 | Master interrupt enable |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| es_clr | input | 1 | Clear pending external/status interrupt |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| sync_n | input | 1 | Sync pin, active low, asynchronous |
| rx_hunt | input | 1 | Receiver hunt flag |
| rx_brk_abort | input | 1 | Receiver break/abort flag |
| tx_eom | input | 1 | Transmit underrun/end-of-message latch |
| zero_cnt | input | 1 | Baud counter zero-count pulse |
| en_rd | output | 8 | Enable register readback |
| es_status | output | 8 | Live or frozen source status |
| es_pending | output | 1 | Pending external/status interrupt |
| es_irq | output | 1 | Interrupt request |
| fifo_en | output | 1 | Frame status buffer enable (enable bit 0) |

## Verification
The assertions check the cycle-level rules on every cycle. They cover the raise one edge after an enabled mismatch or zero-count event, the absence of a raise without one, the frozen status while pending, clear and channel-reset priority, the stored value of a write, and a pending flag that persists until cleared. Other properties need a chain of cycles and only the bench scenarios can show them. These are the synchronizer latency on the pins, the re-raise after a clear for a source that moved while frozen, the switch of bit 4 between pin and hunt flag when the mode changes, and the gating of the request by `mie`.

// File: rtl/extst_pkg.sv
package extst_pkg;

  localparam int ES_W     = 8;
  localparam int NUM_PINS = 3;

  // pin vector order
  localparam int PIN_CTS  = 0;
  localparam int PIN_DCD  = 1;
  localparam int PIN_SYNC = 2;

  // status / enable bit positions (enable bit n guards status bit n)
  localparam int B_BRK  = 7;
  localparam int B_EOM  = 6;
  localparam int B_CTS  = 5;
  localparam int B_SH   = 4;
  localparam int B_DCD  = 3;
  localparam int B_RSV  = 2;
  localparam int B_ZC   = 1;
  localparam int B_FIFO = 0;

  localparam logic [ES_W-1:0] LEVEL_MASK = 8'hF8;
  localparam logic [ES_W-1:0] EN_RESET   = 8'hF8;
  localparam logic [ES_W-1:0] WR_MASK    = ~(ES_W'(1) << B_RSV);

  typedef struct packed {
    logic brk;
    logic eom;
    logic cts;
    logic sh;
    logic dcd;
    logic zc;
  } es_src_t;

  function automatic logic [ES_W-1:0] pack_status(input es_src_t s);
    logic [ES_W-1:0] v;
    v        = '0;
    v[B_BRK] = s.brk;
    v[B_EOM] = s.eom;
    v[B_CTS] = s.cts;
    v[B_SH]  = s.sh;
    v[B_DCD] = s.dcd;
    v[B_ZC]  = s.zc;
    return v;
  endfunction

  function automatic logic [ES_W-1:0] level_hits(input logic [ES_W-1:0] live,
                                                 input logic [ES_W-1:0] ref_v,
                                                 input logic [ES_W-1:0] en);
    return (live ^ ref_v) & en & LEVEL_MASK;
  endfunction

  function automatic logic event_hit(input logic [ES_W-1:0] live,
                                     input logic [ES_W-1:0] en);
    return live[B_ZC] & en[B_ZC];
  endfunction

  function automatic logic [ES_W-1:0] masked_write(input logic [ES_W-1:0] d);
    return d & WR_MASK;
  endfunction

endpackage

// File: rtl/es_pin_sync.sv
module es_pin_sync #(
  parameter int NPINS  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_n,
  output logic [NPINS-1:0] pin_act
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
      end else begin
        chain[0] <= pin_n[g];
        for (int k = 1; k < STAGES; k++) begin
          chain[k] <= chain[k-1];
        end
      end
    end

    assign pin_act[g] = ~chain[STAGES-1];
  end

endmodule

// File: rtl/es_enable_reg.sv
module es_enable_reg
  import extst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chan_rst,
  input  logic            wr,
  input  logic [ES_W-1:0] wdata,
  output logic [ES_W-1:0] en_q
);

  logic [ES_W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (chan_rst)  en_d = EN_RESET;
    else if (wr)   en_d = masked_write(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= EN_RESET;
    else        en_q <= en_d;
  end

  // R11: channel reset restores the enable defaults
  a_r11_chan_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (en_q[7:3] == 5'b11111) && (en_q[2:0] == 3'b000));

  // R2: a write stores the data with the unused bit dropped
  a_r2_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !chan_rst) |=> (en_q[B_RSV] == 1'b0) &&
                          (en_q[7:3] == $past(wdata[7:3])) &&
                          (en_q[1:0] == $past(wdata[1:0])));

endmodule

// File: rtl/es_source_mux.sv
module es_source_mux
  import extst_pkg::*;
(
  input  logic                sync_mode,
  input  logic [NUM_PINS-1:0] pin_act,
  input  logic                rx_hunt,
  input  logic                rx_brk_abort,
  input  logic                tx_eom,
  input  logic                zero_cnt,
  output logic [ES_W-1:0]     live
);

  es_src_t src;

  always_comb begin
    src.brk = rx_brk_abort;
    src.eom = tx_eom;
    src.cts = pin_act[PIN_CTS];
    src.dcd = pin_act[PIN_DCD];
    src.sh  = sync_mode ? rx_hunt : pin_act[PIN_SYNC];
    src.zc  = zero_cnt;
    live    = pack_status(src);
  end

endmodule

// File: rtl/es_change_latch.sv
module es_change_latch
  import extst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chan_rst,
  input  logic            clr,
  input  logic [ES_W-1:0] live,
  input  logic [ES_W-1:0] en,
  output logic            pending_q,
  output logic [ES_W-1:0] snap_q,
  output logic            raise
);

  logic [ES_W-1:0] lvl_hit;
  logic            zc_hit;
  logic            pending_d;
  logic [ES_W-1:0] snap_d;

  assign lvl_hit = level_hits(live, snap_q, en);
  assign zc_hit  = event_hit(live, en);
  assign raise   = !pending_q && !clr && !chan_rst && ((|lvl_hit) || zc_hit);

  always_comb begin
    if (chan_rst) begin
      pending_d = 1'b0;
      snap_d    = live;
    end else if (pending_q) begin
      pending_d = !clr;
      snap_d    = snap_q;
    end else begin
      pending_d = raise;
      snap_d    = live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      snap_q    <= '0;
    end else begin
      pending_q <= pending_d;
      snap_q    <= snap_d;
    end
  end

  // R3: an enabled level mismatch against the held status raises pending
  a_r3_level_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !clr && !chan_rst && (((live ^ snap_q) & en & 8'hF8) != '0))
      |=> pending_q);

  // R4: no enabled mismatch and no enabled event keeps pending low
  a_r4_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && (((live ^ snap_q) & en & 8'hF8) == '0) && !(live[B_ZC] && en[B_ZC]))
      |=> !pending_q);

  // R6: zero-count pulse with its enable raises pending and is recorded
  a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !clr && !chan_rst && live[B_ZC] && en[B_ZC])
      |=> pending_q && snap_q[B_ZC]);

  // R7: status stays frozen while pending
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !chan_rst) |=> $stable(snap_q));

  // R8: clear drops pending on the next edge
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pending_q);

  // R10: pending persists without clear or channel reset
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !clr && !chan_rst) |=> pending_q);

  // R11: channel reset drops pending
  a_r11_chan_clear: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !pending_q);

endmodule

// File: rtl/extstat_irq_unit.sv
module extstat_irq_unit
  import extst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_rst,
  input  logic       sync_mode,
  input  logic       mie,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  input  logic       es_clr,
  input  logic       cts_n,
  input  logic       dcd_n,
  input  logic       sync_n,
  input  logic       rx_hunt,
  input  logic       rx_brk_abort,
  input  logic       tx_eom,
  input  logic       zero_cnt,
  output logic [7:0] en_rd,
  output logic [7:0] es_status,
  output logic       es_pending,
  output logic       es_irq,
  output logic       fifo_en
);

  logic [NUM_PINS-1:0] pin_n;
  logic [NUM_PINS-1:0] pin_act;
  logic [ES_W-1:0]     en_q;
  logic [ES_W-1:0]     live;
  logic [ES_W-1:0]     snap_q;
  logic                pending_q;
  logic                raise;

  always_comb begin
    pin_n           = '1;
    pin_n[PIN_CTS]  = cts_n;
    pin_n[PIN_DCD]  = dcd_n;
    pin_n[PIN_SYNC] = sync_n;
  end

  es_pin_sync #(
    .NPINS  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (pin_n),
    .pin_act (pin_act)
  );

  es_enable_reg u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_rst (chan_rst),
    .wr       (en_wr),
    .wdata    (en_wdata),
    .en_q     (en_q)
  );

  es_source_mux u_mux (
    .sync_mode    (sync_mode),
    .pin_act      (pin_act),
    .rx_hunt      (rx_hunt),
    .rx_brk_abort (rx_brk_abort),
    .tx_eom       (tx_eom),
    .zero_cnt     (zero_cnt),
    .live         (live)
  );

  es_change_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_rst  (chan_rst),
    .clr       (es_clr),
    .live      (live),
    .en        (en_q),
    .pending_q (pending_q),
    .snap_q    (snap_q),
    .raise     (raise)
  );

  assign en_rd      = en_q;
  assign es_status  = snap_q;
  assign es_pending = pending_q;
  assign es_irq     = pending_q & mie;
  assign fifo_en    = en_q[B_FIFO];

  // R9: no request without master enable, and a pending flag with mie requests
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!mie |-> !es_irq) and ((es_pending && mie) |-> es_irq));

  // R3: a raise is followed by a pending flag unless a channel reset intervenes
  a_r3_raise_lands: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> es_pending);

endmodule

// File: tb/test_extstat_irq_unit.sv
module test_extstat_irq_unit;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, chan_rst = 1'b0, sync_mode = 1'b0, mie = 1'b0;
  logic       en_wr = 1'b0, es_clr = 1'b0;
  logic [7:0] en_wdata = 8'h00;
  logic       cts_n = 1'b1, dcd_n = 1'b1, sync_n = 1'b1;
  logic       rx_hunt = 1'b0, rx_brk_abort = 1'b0, tx_eom = 1'b0, zero_cnt = 1'b0;
  logic [7:0] en_rd, es_status;
  logic       es_pending, es_irq, fifo_en;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R3";
  bit    done = 1'b0;

  // bench model state
  logic [2:0] m_s1 = 3'b111, m_s2 = 3'b111;   // {sync, dcd, cts} raw pins
  logic [7:0] m_en = 8'hF8, m_snap = 8'h00;
  logic       m_pend = 1'b0;

  extstat_irq_unit i_extstat_irq_unit (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .sync_mode(sync_mode), .mie(mie),
    .en_wr(en_wr), .en_wdata(en_wdata), .es_clr(es_clr),
    .cts_n(cts_n), .dcd_n(dcd_n), .sync_n(sync_n),
    .rx_hunt(rx_hunt), .rx_brk_abort(rx_brk_abort), .tx_eom(tx_eom), .zero_cnt(zero_cnt),
    .en_rd(en_rd), .es_status(es_status), .es_pending(es_pending), .es_irq(es_irq),
    .fifo_en(fifo_en)
  );

  // status image from the requirement layout (R3, R5)
  function automatic logic [7:0] f_live(input logic [2:0] s2, input logic mode,
                                        input logic b, input logic e,
                                        input logic h, input logic z);
    logic slot4;
    slot4 = mode ? h : ~s2[2];
    return {b, e, ~s2[0], slot4, ~s2[1], 1'b0, z, 1'b0};
  endfunction

  function automatic logic [7:0] f_hits(input logic [7:0] live, input logic [7:0] held,
                                        input logic [7:0] en, input logic z);
    logic [7:0] h;
    h = 8'h00;
    for (int i = 3; i < 8; i++) h[i] = (live[i] != held[i]) && en[i];
    h[1] = z && en[1];
    return h;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(cur_req, "enable", en_rd, m_en);
    chk(cur_req, "status", es_status, m_snap);
    chk(cur_req, "pending", {7'd0, es_pending}, {7'd0, m_pend});
    chk(cur_req, "irq (R9)", {7'd0, es_irq}, {7'd0, m_pend & mie});
    chk(cur_req, "fifo_en (R12)", {7'd0, fifo_en}, {7'd0, m_en[0]});
  endtask

  // one clock: predict, clock, commit, compare; called and returns at negedge
  task automatic step();
    logic [7:0] live, hits, n_en, n_snap;
    logic       n_pend;
    logic [2:0] pins;
    pins = {sync_n, dcd_n, cts_n};
    live = f_live(m_s2, sync_mode, rx_brk_abort, tx_eom, rx_hunt, zero_cnt);
    hits = f_hits(live, m_snap, m_en, zero_cnt);
    if (chan_rst) begin
      n_en = 8'hF8; n_pend = 1'b0; n_snap = live;
    end else begin
      n_en = en_wr ? {en_wdata[7:3], 1'b0, en_wdata[1:0]} : m_en;
      if (m_pend) begin
        n_pend = !es_clr; n_snap = m_snap;
      end else begin
        n_pend = !es_clr && (hits != 8'h00); n_snap = live;
      end
    end
    @(posedge clk);
    #2;
    m_s2 = m_s1; m_s1 = pins;
    m_en = n_en; m_pend = n_pend; m_snap = n_snap;
    compare_model();
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_en(input logic [7:0] d);
    en_wr = 1'b1; en_wdata = d; step(); en_wr = 1'b0;
  endtask

  task automatic clear_es();
    es_clr = 1'b1; step(); es_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "enable", en_rd, 8'hF8);
    chk("R1", "status", es_status, 8'h00);
    chk("R1", "pending", {7'd0, es_pending}, 8'h00);
    chk("R1", "irq", {7'd0, es_irq}, 8'h00);
    chk("R1", "fifo_en", {7'd0, fifo_en}, 8'h00);
    @(negedge clk);

    // R2 / R12 write masking and bit 0 output
    cur_req = "R2";
    write_en(8'hFF);
    chk("R2", "bit2 dropped", en_rd, 8'hFB);
    chk("R12", "fifo_en", {7'd0, fifo_en}, 8'h01);
    write_en(8'h04);
    chk("R2", "bit2 only write", en_rd, 8'h00);
    chk("R2", "no pending", {7'd0, es_pending}, 8'h00);

    // R3 rising change on break/abort
    cur_req = "R3";
    write_en(8'hF8);
    mie = 1'b1;
    rx_brk_abort = 1'b1; step();
    chk("R3", "pending after rise", {7'd0, es_pending}, 8'h01);
    chk("R3", "status", es_status, 8'h80);
    chk("R9", "irq with mie", {7'd0, es_irq}, 8'h01);

    // R7 frozen while pending
    cur_req = "R7";
    tx_eom = 1'b1; steps(2);
    chk("R7", "status frozen", es_status, 8'h80);

    // R8 clear then re-raise for source moved while frozen
    cur_req = "R8";
    clear_es();
    chk("R8", "cleared", {7'd0, es_pending}, 8'h00);
    step();
    chk("R8", "re-raise", {7'd0, es_pending}, 8'h01);
    chk("R8", "new snapshot", es_status, 8'hC0);
    clear_es(); steps(2);
    chk("R8", "stays clear", {7'd0, es_pending}, 8'h00);

    // R3 falling change
    cur_req = "R3";
    rx_brk_abort = 1'b0; step();
    chk("R3", "pending after fall", {7'd0, es_pending}, 8'h01);
    chk("R3", "status after fall", es_status, 8'h40);
    clear_es(); step();

    // R4 disabled pin change tracked but silent
    cur_req = "R4";
    write_en(8'h00);
    cts_n = 1'b0; steps(3);
    chk("R4", "no pending", {7'd0, es_pending}, 8'h00);
    chk("R4", "status tracks", es_status, 8'h60);

    // R9 gating, R3 pin latency
    cur_req = "R9";
    mie = 1'b0;
    write_en(8'h20);
    cts_n = 1'b1; steps(2);
    chk("R3", "pin not yet through", {7'd0, es_pending}, 8'h00);
    step();
    chk("R3", "pin third edge", {7'd0, es_pending}, 8'h01);
    chk("R9", "irq masked", {7'd0, es_irq}, 8'h00);
    mie = 1'b1; #1;
    chk("R9", "irq unmasked", {7'd0, es_irq}, 8'h01);
    @(negedge clk);
    clear_es(); step();

    // R5 bit 4 source selection
    cur_req = "R5";
    write_en(8'h10);
    rx_hunt = 1'b1; steps(3);
    chk("R5", "hunt ignored async", {7'd0, es_pending}, 8'h00);
    sync_n = 1'b0; steps(3);
    chk("R5", "sync pin async", {7'd0, es_pending}, 8'h01);
    chk("R5", "status bit4", es_status, 8'h50);
    clear_es(); step();
    sync_mode = 1'b1; step();
    chk("R5", "mode switch equal", {7'd0, es_pending}, 8'h00);
    rx_hunt = 1'b0; step();
    chk("R5", "hunt in sync mode", {7'd0, es_pending}, 8'h01);
    chk("R5", "status hunt", es_status, 8'h40);
    clear_es(); step();
    sync_n = 1'b1; steps(3);
    chk("R5", "pin ignored sync", {7'd0, es_pending}, 8'h00);
    sync_mode = 1'b0; step();

    // R6 zero count event
    cur_req = "R6";
    write_en(8'h02);
    zero_cnt = 1'b1; step(); zero_cnt = 1'b0;
    chk("R6", "pending", {7'd0, es_pending}, 8'h01);
    chk("R6", "status bit1", es_status, 8'h42);
    clear_es(); step();
    chk("R6", "status after clear", es_status, 8'h40);

    // R10 write does not drop pending
    cur_req = "R10";
    zero_cnt = 1'b1; step(); zero_cnt = 1'b0;
    write_en(8'h00);
    chk("R10", "pending kept", {7'd0, es_pending}, 8'h01);
    chk("R10", "enable zero", en_rd, 8'h00);

    // R11 channel reset beats write
    cur_req = "R11";
    chan_rst = 1'b1; en_wr = 1'b1; en_wdata = 8'h07; step();
    chan_rst = 1'b0; en_wr = 1'b0;
    chk("R11", "enable defaults", en_rd, 8'hF8);
    chk("R11", "pending cleared", {7'd0, es_pending}, 8'h00);

    // random phase against the bench model
    cur_req = "R3";
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(3, 0) == 0) rx_brk_abort = ~rx_brk_abort;
      if ($urandom_range(3, 0) == 0) tx_eom = ~tx_eom;
      if ($urandom_range(3, 0) == 0) rx_hunt = ~rx_hunt;
      if ($urandom_range(7, 0) == 0) cts_n = ~cts_n;
      if ($urandom_range(7, 0) == 0) dcd_n = ~dcd_n;
      if ($urandom_range(7, 0) == 0) sync_n = ~sync_n;
      if ($urandom_range(49, 0) == 0) sync_mode = ~sync_mode;
      if ($urandom_range(7, 0) == 0) mie = ~mie;
      zero_cnt = ($urandom_range(15, 0) == 0);
      es_clr   = ($urandom_range(5, 0) == 0);
      chan_rst = ($urandom_range(63, 0) == 0);
      en_wr    = ($urandom_range(19, 0) == 0);
      en_wdata = 8'($urandom);
      step();
    end
    zero_cnt = 1'b0; es_clr = 1'b0; chan_rst = 1'b0; en_wr = 1'b0;
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule